// File: doc/BRIEF.md
# Multi-Channel Doorbell Mailbox

This block carries short messages between a host processor and a remote microcontroller over twelve independent channels. The host has one 32-bit register port with two windows, chosen by a select input. The data window is flat word storage. Each channel owns an outgoing area and an incoming area inside it, and those areas differ in length. The control window holds per-channel doorbell, clear and status bits. Bit n of every control register belongs to channel n.

To send, the host writes the message words into the channel's outgoing area and then rings that channel's doorbell. The remote agent sees the pending bit, reads the words through its own data port and pulses a consume strobe. To reply, the remote agent writes the channel's incoming area and pulses a post strobe. The post sets a receive status bit and raises the shared host interrupt. The host reads the reply and clears the bit with a write-one-to-clear access.

Top module: `mbx_top`

## Requirements
- R1: After reset, every transmit and receive status bit is 0, `tx_pend_o` is 0 and `irq_o` is low.
- R2: A host write of a word to data-window byte address A (below 0x170, low two bits ignored) stores it. A host read request returns the stored word on `h_rdata_o` in the following cycle. In a cycle after no read request, `h_rdata_o` is 0.
- R3: A host control write to offset 0x04 sets transmit status bit n for every bit n that is 1 in the written data. Bits written as 0 have no effect. Transmit status reads back at control offset 0x00 and drives `tx_pend_o`.
- R4: A pulse on `r_consume_i[n]` clears transmit bit n. If a doorbell for channel n arrives in the same cycle, the bit stays set.
- R5: A pulse on `r_post_i[n]` sets receive status bit n, which reads back at control offset 0x78.
- R6: A host control write to offset 0x74 clears receive bit n for every bit n that is 1 in the written data. If a post for channel n arrives in the same cycle, the bit stays set.
- R7: `irq_o` is high exactly while at least one receive status bit is set.
- R8: Data-window accesses at byte addresses 0x170 and above read 0, and writes to them are ignored.
- R9: Host writes to control offsets 0x00 and 0x78 are ignored. Reads of offsets 0x04, 0x74 and any other undefined control offset return 0.
- R10: The remote port reads and writes the same storage with a one-cycle read latency. When both ports write the same word in the same cycle, the remote value is kept.
- R11: The data window is sized to end exactly at the last incoming area (0x16C, 4 bytes), so 0x16C is storage and 0x170 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| h_req_i | input | 1 | Host access request |
| h_we_i | input | 1 | Host write (1) or read (0) |
| h_ctl_i | input | 1 | Host window select: 1 control, 0 data |
| h_addr_i | input | 9 | Host byte address within the window |
| h_wdata_i | input | 32 | Host write data |
| h_rdata_o | output | 32 | Host read data, one cycle after request |
| r_req_i | input | 1 | Remote data access request |
| r_we_i | input | 1 | Remote write (1) or read (0) |
| r_addr_i | input | 9 | Remote byte address in data window |
| r_wdata_i | input | 32 | Remote write data |
| r_rdata_o | output | 32 | Remote read data, one cycle after request |
| r_consume_i | input | 12 | Per-channel consume strobes |
| r_post_i | input | 12 | Per-channel post strobes |
| tx_pend_o | output | 12 | Transmit status, doorbell toward remote |
| irq_o | output | 1 | Level interrupt toward host |

## Verification
The hardest cases to reach are the same-cycle collisions, where a doorbell meets a consume or a host clear meets a post on the same channel. Also hard is the case where both ports write one storage word in the same cycle. The bench drives dense pseudo-random strobes and control writes whose masks cover many channels at once, so these overlaps happen often. It also pins down each collision with directed cycles that force it on a chosen channel. The data reference model is first filled through every in-range word, so every later read compares against a known value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NCH = 12;
  localparam int DW  = 32;
  localparam int AW  = 9;

  localparam int TX_OFF [NCH] = '{'h000, 'h010, 'h030, 'h03C, 'h054, 'h078,
                                  'h088, 'h0A0, 'h0B8, 'h0BC, 'h0CC, 'h0DC};
  localparam int TX_LEN [NCH] = '{16, 32, 12, 24, 36, 16, 24, 24, 4, 16, 16, 4};
  localparam int RX_OFF [NCH] = '{'h0E0, 'h0F0, 'h110, 'h114, 'h118, 'h11C,
                                  'h12C, 'h130, 'h148, 'h158, 'h15C, 'h16C};
  localparam int RX_LEN [NCH] = '{16, 32, 4, 4, 4, 16, 4, 24, 16, 4, 16, 4};

  // control window offsets
  localparam logic [AW-1:0] CTL_TX_STS = 9'h000;
  localparam logic [AW-1:0] CTL_DB_SET = 9'h004;
  localparam logic [AW-1:0] CTL_RX_CLR = 9'h074;
  localparam logic [AW-1:0] CTL_RX_STS = 9'h078;

  function automatic int window_end();
    int e;
    e = 0;
    for (int i = 0; i < NCH; i++) begin
      if (TX_OFF[i] + TX_LEN[i] > e) e = TX_OFF[i] + TX_LEN[i];
      if (RX_OFF[i] + RX_LEN[i] > e) e = RX_OFF[i] + RX_LEN[i];
    end
    return e;
  endfunction

  localparam int DATA_BYTES = window_end();
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int AW    = 9,
  parameter int DW    = 32,
  parameter int BYTES = 368
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_req_i,
  input  logic          h_we_i,
  input  logic [AW-1:0] h_addr_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rdata_o,
  input  logic          r_req_i,
  input  logic          r_we_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic [DW-1:0] r_wdata_i,
  output logic [DW-1:0] r_rdata_o
);
  localparam int WORDS = BYTES / 4;
  localparam int IW    = $clog2(WORDS);

  logic [DW-1:0] mem [WORDS];
  logic [IW-1:0] h_idx, r_idx;
  logic          h_in, r_in;

  assign h_in  = 32'(h_addr_i) < BYTES;
  assign r_in  = 32'(r_addr_i) < BYTES;
  assign h_idx = h_addr_i[IW+1:2];
  assign r_idx = r_addr_i[IW+1:2];

  // remote write ordered last: it wins on a same-word collision
  always_ff @(posedge clk_i) begin
    if (h_req_i && h_we_i && h_in) mem[h_idx] <= h_wdata_i;
    if (r_req_i && r_we_i && r_in) mem[r_idx] <= r_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_rdata_o <= '0;
      r_rdata_o <= '0;
    end else begin
      h_rdata_o <= (h_req_i && !h_we_i && h_in) ? mem[h_idx] : '0;
      r_rdata_o <= (r_req_i && !r_we_i && r_in) ? mem[r_idx] : '0;
    end
  end

  assert_oor_read_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_req_i && !h_we_i && !h_in) |=> (h_rdata_o == '0));
endmodule

// File: rtl/mbx_status.sv
module mbx_status #(
  parameter int NCH = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] db_set_i,
  input  logic [NCH-1:0] consume_i,
  input  logic [NCH-1:0] post_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] tx_q_o,
  output logic [NCH-1:0] rx_q_o
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_q_o[n] <= 1'b0;
        rx_q_o[n] <= 1'b0;
      end else begin
        if (db_set_i[n])       tx_q_o[n] <= 1'b1;
        else if (consume_i[n]) tx_q_o[n] <= 1'b0;
        if (post_i[n])         rx_q_o[n] <= 1'b1;
        else if (clr_i[n])     rx_q_o[n] <= 1'b0;
      end
    end

    assert_db_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      db_set_i[n] |=> tx_q_o[n]);
    assert_consume_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (consume_i[n] && !db_set_i[n]) |=> !tx_q_o[n]);
    assert_post_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      post_i[n] |=> rx_q_o[n]);
    assert_clr_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[n] && !post_i[n]) |=> !rx_q_o[n]);
  end
endmodule

// File: rtl/mbx_ctl_regs.sv
module mbx_ctl_regs
  import mbx_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           h_req_i,
  input  logic           h_we_i,
  input  logic           h_ctl_i,
  input  logic [AW-1:0]  h_addr_i,
  input  logic [DW-1:0]  h_wdata_i,
  input  logic [NCH-1:0] tx_i,
  input  logic [NCH-1:0] rx_i,
  output logic [NCH-1:0] db_set_o,
  output logic [NCH-1:0] clr_o,
  output logic [DW-1:0]  ctl_rdata_o,
  output logic           sel_ctl_o
);
  logic          wr, rd;
  logic [AW-1:0] off;

  assign wr  = h_req_i && h_ctl_i && h_we_i;
  assign rd  = h_req_i && h_ctl_i && !h_we_i;
  assign off = {h_addr_i[AW-1:2], 2'b00};

  assign db_set_o = (wr && off == CTL_DB_SET) ? h_wdata_i[NCH-1:0] : '0;
  assign clr_o    = (wr && off == CTL_RX_CLR) ? h_wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_rdata_o <= '0;
      sel_ctl_o   <= 1'b0;
    end else begin
      sel_ctl_o <= rd;
      if (rd && off == CTL_TX_STS)      ctl_rdata_o <= DW'(tx_i);
      else if (rd && off == CTL_RX_STS) ctl_rdata_o <= DW'(rx_i);
      else                              ctl_rdata_o <= '0;
    end
  end
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           h_req_i,
  input  logic           h_we_i,
  input  logic           h_ctl_i,
  input  logic [AW-1:0]  h_addr_i,
  input  logic [DW-1:0]  h_wdata_i,
  output logic [DW-1:0]  h_rdata_o,
  input  logic           r_req_i,
  input  logic           r_we_i,
  input  logic [AW-1:0]  r_addr_i,
  input  logic [DW-1:0]  r_wdata_i,
  output logic [DW-1:0]  r_rdata_o,
  input  logic [NCH-1:0] r_consume_i,
  input  logic [NCH-1:0] r_post_i,
  output logic [NCH-1:0] tx_pend_o,
  output logic           irq_o
);
  logic [NCH-1:0] db_set, clr, tx_q, rx_q;
  logic [DW-1:0]  st_rdata, ctl_rdata;
  logic           sel_ctl;

  mbx_store #(.AW(AW), .DW(DW), .BYTES(DATA_BYTES)) u_store (
    .clk_i, .rst_ni,
    .h_req_i(h_req_i && !h_ctl_i), .h_we_i, .h_addr_i, .h_wdata_i,
    .h_rdata_o(st_rdata),
    .r_req_i, .r_we_i, .r_addr_i, .r_wdata_i, .r_rdata_o
  );

  mbx_ctl_regs #(.NCH(NCH)) u_ctl (
    .clk_i, .rst_ni, .h_req_i, .h_we_i, .h_ctl_i, .h_addr_i, .h_wdata_i,
    .tx_i(tx_q), .rx_i(rx_q), .db_set_o(db_set), .clr_o(clr),
    .ctl_rdata_o(ctl_rdata), .sel_ctl_o(sel_ctl)
  );

  mbx_status #(.NCH(NCH)) u_sts (
    .clk_i, .rst_ni, .db_set_i(db_set), .consume_i(r_consume_i),
    .post_i(r_post_i), .clr_i(clr), .tx_q_o(tx_q), .rx_q_o(rx_q)
  );

  assign h_rdata_o = sel_ctl ? ctl_rdata : st_rdata;
  assign tx_pend_o = tx_q;
  assign irq_o     = |rx_q;

  assert_irq_rise_needs_post_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|r_post_i));
  assert_irq_fall_needs_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(h_req_i && h_ctl_i && h_we_i));
  assert_tx_rise_needs_db_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pend_o != '0 && $past(tx_pend_o) == '0) |-> $past(h_req_i && h_ctl_i && h_we_i));
endmodule

// File: tb/mbx_top_test.sv
module mbx_top_test;
  localparam int NCH = 12;
  localparam int BYTES = 'h170;

  logic clk = 0, rst_n = 0;
  logic h_req = 0, h_we = 0, h_ctl = 0, r_req = 0, r_we = 0;
  logic [8:0] h_addr = 0, r_addr = 0;
  logic [31:0] h_wdata = 0, r_wdata = 0;
  logic [NCH-1:0] consume = 0, post = 0;
  wire  [31:0] h_rdata, r_rdata;
  wire  [NCH-1:0] tx_pend;
  wire  irq;

  always #5 clk = ~clk;

  mbx_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .h_req_i(h_req), .h_we_i(h_we), .h_ctl_i(h_ctl), .h_addr_i(h_addr),
    .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .r_req_i(r_req), .r_we_i(r_we), .r_addr_i(r_addr), .r_wdata_i(r_wdata),
    .r_rdata_o(r_rdata), .r_consume_i(consume), .r_post_i(post),
    .tx_pend_o(tx_pend), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit model_on = 0;

  // reference model
  int unsigned mem [BYTES/4];
  bit known [BYTES/4];
  int unsigned m_tx = 0, m_rx = 0;
  int unsigned e_hrd = 0, e_rrd = 0;
  bit e_hvalid = 1, e_rvalid = 1;
  string e_htag = "R1";

  task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; e_hrd = 0; e_rrd = 0; e_hvalid = 1; e_rvalid = 1; e_htag = "R1";
    end else begin
      int unsigned ha, ra, w;
      ha = h_addr; ra = r_addr;
      e_hrd = 0; e_hvalid = 1; e_htag = "R2";
      if (h_req && !h_we) begin
        if (h_ctl) begin
          w = ha & 'h1FC;
          if (w == 0) begin e_hrd = m_tx; e_htag = "R3"; end
          else if (w == 'h78) begin e_hrd = m_rx; e_htag = "R5"; end
          else e_htag = "R9";
        end else if (ha < BYTES) begin
          e_hrd = mem[ha/4]; e_hvalid = known[ha/4];
        end else e_htag = "R8";
      end
      e_rrd = 0; e_rvalid = 1;
      if (r_req && !r_we && ra < BYTES) begin e_rrd = mem[ra/4]; e_rvalid = known[ra/4]; end
      if (h_req && h_we && !h_ctl && ha < BYTES) begin mem[ha/4] = h_wdata; known[ha/4] = 1; end
      if (r_req && r_we && ra < BYTES) begin mem[ra/4] = r_wdata; known[ra/4] = 1; end
      begin
        int unsigned db, cl;
        w = ha & 'h1FC;
        db = (h_req && h_we && h_ctl && w == 4) ? (h_wdata & 'hFFF) : 0;
        cl = (h_req && h_we && h_ctl && w == 'h74) ? (h_wdata & 'hFFF) : 0;
        m_tx = ((m_tx & ~consume) | db) & 'hFFF;
        m_rx = ((m_rx & ~cl) | post) & 'hFFF;
      end
    end
  end

  always @(negedge clk) if (model_on) begin
    if (e_hvalid) chk(h_rdata == e_hrd, e_htag, h_rdata, e_hrd);
    if (e_rvalid) chk(r_rdata == e_rrd, "R10", r_rdata, e_rrd);
    chk(tx_pend == m_tx[NCH-1:0], "R4", tx_pend, m_tx);
    chk(irq == (m_rx != 0), "R7", irq, m_rx != 0);
  end

  task automatic idle();
    h_req = 0; h_we = 0; h_ctl = 0; r_req = 0; r_we = 0; consume = 0; post = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; @(negedge clk); #1;
  endtask

  task automatic hwr(bit ctl, int unsigned a, int unsigned d);
    idle(); h_req = 1; h_we = 1; h_ctl = ctl; h_addr = 9'(a); h_wdata = d; step();
  endtask

  task automatic hrd(bit ctl, int unsigned a);
    idle(); h_req = 1; h_ctl = ctl; h_addr = 9'(a); step();
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset values
    chk(tx_pend == 0, "R1", tx_pend, 0);
    chk(irq == 0, "R1", irq, 0);
    rst_n = 1;
    @(negedge clk); #1;
    model_on = 1;
    // R2: fill every in-range word
    for (int i = 0; i < BYTES/4; i++) hwr(0, i*4, 32'h5A000000 + i*32'h01010101);
    hrd(0, 'h16C);
    idle(); step();
    // R11: last incoming area word is storage, next word is not
    hwr(0, 'h170, 32'hDEAD);
    hrd(0, 'h170);
    chk(h_rdata == 0, "R11", h_rdata, 0);
    hrd(0, 'h16C);
    chk(h_rdata == mem['h16C/4], "R11", h_rdata, mem['h16C/4]);
    // R3/R4: doorbell collides with consume on ch 2
    hwr(1, 4, 32'h0000_0005);
    idle(); h_req = 1; h_we = 1; h_ctl = 1; h_addr = 4; h_wdata = 32'h4; consume = 12'h005; step();
    chk(tx_pend == 12'h004, "R4", tx_pend, 12'h004);
    // R9: writes to status offsets ignored
    hwr(1, 0, 32'hFFF);
    hwr(1, 'h78, 32'hFFF);
    chk(tx_pend == 12'h004 && irq == 0, "R9", {tx_pend, irq}, {12'h004, 1'b0});
    hrd(1, 4); hrd(1, 'h74);
    // R5/R6: post collides with clear on ch 3
    idle(); post = 12'h808; step();
    hrd(1, 'h78);
    chk(h_rdata == 32'h808, "R5", h_rdata, 32'h808);
    idle(); h_req = 1; h_we = 1; h_ctl = 1; h_addr = 'h74; h_wdata = 32'h808; post = 12'h008; step();
    chk(irq == 1, "R6", irq, 1);
    hwr(1, 'h74, 32'h008);
    chk(irq == 0, "R6", irq, 0);
    // R10: same-word write collision, remote kept
    idle(); h_req = 1; h_we = 1; h_addr = 'h40; h_wdata = 32'h1111;
    r_req = 1; r_we = 1; r_addr = 'h40; r_wdata = 32'h2222; step();
    idle(); r_req = 1; r_addr = 'h40; step();
    chk(r_rdata == 32'h2222, "R10", r_rdata, 32'h2222);
    // pseudo-random traffic
    for (int k = 0; k < 4000; k++) begin
      int unsigned sel;
      idle();
      h_req = $urandom_range(0, 1);
      h_we = $urandom_range(0, 1);
      h_ctl = $urandom_range(0, 1);
      sel = $urandom_range(0, 5);
      if (h_ctl) h_addr = (sel == 0) ? 9'h0 : (sel == 1) ? 9'h4 : (sel == 2) ? 9'h74 :
                          (sel == 3) ? 9'h78 : (sel == 4) ? 9'h10 : 9'h7A;
      else h_addr = 9'($urandom_range(0, 127) * 4);
      h_wdata = $urandom;
      r_req = $urandom_range(0, 1);
      r_we = $urandom_range(0, 1);
      r_addr = (sel == 5) ? h_addr : 9'($urandom_range(0, 127) * 4);
      r_wdata = $urandom;
      consume = 12'($urandom) & 12'($urandom);
      post = 12'($urandom) & 12'($urandom) & 12'($urandom);
      step();
    end
    idle(); step();
    model_on = 0;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule